// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block turns the control pins of a 6-bit digital step attenuator into one registered attenuation word in 0.5 dB steps. A mode pin picks either a parallel path (six control inputs) or a serial path (data and clock into a 6-bit shift register). Both paths share one latch-enable pin. In parallel mode, latch enable high makes the word follow the inputs directly, and a high-then-low pulse captures a value. In serial mode, latch enable high makes the output latch transparent to the shift register.

The serial clock, serial data and latch enable inputs each pass through a two-flop synchronizer into the system clock domain. Clock edges are detected in that domain. A synchronous active-low reset stands in for power-up. It loads a defined word that depends on the mode pin, the latch enable pin, the two preset pins and the parallel inputs, sampled on the last reset cycle.

Top module: `step_atten_ctrl`

## Requirements
- R1: `ser_mode` low selects the parallel path and high selects the serial path. In parallel mode, serial clocking never changes `atten`.
- R2: `atten` bit k weighs 0.5·2^k dB (bit 0 = 0.5 dB, bit 5 = 16 dB). All ones gives 31.5 dB and all zeros gives minimum loss.
- R3: In parallel mode with `lat_en` high, `atten` follows `par_word`.
- R4: In parallel mode with `lat_en` low, changes on `par_word` leave `atten` unchanged. A high-then-low pulse on `lat_en` captures the `par_word` value present while it was high.
- R5: Each rising edge of `sclk` shifts `sdata` into bit 0 of the shift register, and the older bits move toward bit 5. The first bit sent therefore ends in bit 5 (16 dB) after six clocks. Shifting happens whatever the level of `lat_en`.
- R6: In serial mode, `atten` tracks the shift register while `lat_en` is high and holds its value while `lat_en` is low.
- R7: At reset in serial mode, `atten` and the shift register load `par_word`.
- R8: At reset in parallel mode with `lat_en` low, `atten` comes from `pup` = {hi,lo}: 00 → 000000, 10 → 010000 (8 dB), 01 → 100000 (16 dB), 11 → 111110 (31 dB).
- R9: At reset in parallel mode with `lat_en` high, `pup` is ignored and `atten` loads `par_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up model) |
| ser_mode | input | 1 | 0 = parallel path, 1 = serial path |
| par_word | input | 6 | Parallel control word, bit 0 = 0.5 dB |
| sdata | input | 1 | Serial data, asynchronous |
| sclk | input | 1 | Serial shift clock, asynchronous |
| lat_en | input | 1 | Shared latch enable, asynchronous |
| pup | input | 2 | Reset preset select {hi, lo} |
| atten | output | 6 | Registered attenuation word |

## Verification
A corrupt shift register stays hidden while the latch is closed. It shows at `atten` about three system clocks after `lat_en` rises in serial mode, so every serial check opens the latch after the word has been loaded. A wrong reset decode or a wrong preset path shows on the first cycle after reset is released, and it stays visible for as long as `lat_en` is low. A latch that leaks shows within a few cycles of a `par_word` change or an `sclk` edge made while the latch is closed, and the bench makes both kinds of change.

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int WORD_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode,
  input  logic [WORD_W-1:0] par_word,
  input  logic              sdata,
  input  logic              sclk,
  input  logic              lat_en,
  input  logic [1:0]        pup,
  output logic [WORD_W-1:0] atten
);

  localparam logic [WORD_W-1:0] W_ZERO = '0;
  localparam logic [WORD_W-1:0] W_8DB  = WORD_W'(1) << (WORD_W - 2);
  localparam logic [WORD_W-1:0] W_16DB = WORD_W'(1) << (WORD_W - 1);
  localparam logic [WORD_W-1:0] W_TOP  = {WORD_W{1'b1}} << 1;

  logic [SYNC_STAGES-1:0] sclk_q, sdat_q, le_q;
  logic                   sclk_d;
  logic                   sclk_s, sdat_s, le_s, sclk_rise;
  logic [WORD_W-1:0]      shreg, pup_word, rst_word;

  assign sclk_s    = sclk_q[SYNC_STAGES-1];
  assign sdat_s    = sdat_q[SYNC_STAGES-1];
  assign le_s      = le_q[SYNC_STAGES-1];
  assign sclk_rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= {SYNC_STAGES{sclk}};
      sdat_q <= {SYNC_STAGES{sdata}};
      le_q   <= {SYNC_STAGES{lat_en}};
      sclk_d <= sclk;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
      sdat_q <= {sdat_q[SYNC_STAGES-2:0], sdata};
      le_q   <= {le_q[SYNC_STAGES-2:0], lat_en};
      sclk_d <= sclk_s;
    end
  end

  always_comb begin
    case (pup)
      2'b00:   pup_word = W_ZERO;
      2'b10:   pup_word = W_8DB;
      2'b01:   pup_word = W_16DB;
      default: pup_word = W_TOP;
    endcase
  end

  assign rst_word = (ser_mode || lat_en) ? par_word : pup_word;

  always_ff @(posedge clk) begin
    if (!rst_n)         shreg <= par_word;
    else if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdat_s};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    atten <= rst_word;
    else if (le_s) atten <= ser_mode ? shreg : par_word;
  end

  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !le_s |=> $stable(atten)); // R4
  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && le_s) |=> atten == $past(par_word)); // R3
  AST_SER_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && le_s) |=> atten == $past(shreg)); // R6
  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(shreg)); // R5
  AST_RST_SERIAL: assert property (@(posedge clk)
    (!rst_n && ser_mode) |=> atten == $past(par_word)); // R7
  AST_RST_PUP_TOP: assert property (@(posedge clk)
    (!rst_n && !ser_mode && !lat_en && pup == 2'b11) |=> atten == W_TOP); // R8
  AST_RST_DIRECT: assert property (@(posedge clk)
    (!rst_n && !ser_mode && lat_en) |=> atten == $past(par_word)); // R9

endmodule

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;

  typedef struct {
    logic [5:0] val;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_mode = 1'b1;
  logic [5:0] par_word = 6'b101101;
  logic       sdata = 1'b0;
  logic       sclk = 1'b0;
  logic       lat_en = 1'b0;
  logic [1:0] pup = 2'b00;
  logic [5:0] atten;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  step_atten_ctrl i_step_atten_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .par_word(par_word),
    .sdata(sdata), .sclk(sclk), .lat_en(lat_en), .pup(pup), .atten(atten)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_word(input logic [5:0] v, input string tag);
    exp_t e;
    repeat (8) @(posedge clk);
    e.val = v;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset(input logic m, input logic le, input logic [1:0] p,
                          input logic [5:0] w);
    tick(1);
    rst_n = 1'b0; ser_mode = m; lat_en = le; pup = p; par_word = w; sclk = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic shift_word(input logic [5:0] w, input int nbits);
    for (int i = 5; i > 5 - nbits; i--) begin
      sdata = w[i];
      tick(3);
      sclk = 1'b1;
      tick(3);
      sclk = 1'b0;
      tick(3);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (atten !== e.val) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", e.tag, atten, e.val);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R7 serial reset loads parallel pins
    do_reset(1'b1, 1'b0, 2'b11, 6'b101101);
    expect_word(6'b101101, "R7 serial reset preset");
    // R5 shift with latch closed, R6 hold
    shift_word(6'b110010, 6);
    par_word = 6'b000000;
    expect_word(6'b101101, "R6 closed latch holds during shift");
    lat_en = 1'b1;
    expect_word(6'b110010, "R5 MSB-first shift visible");
    lat_en = 1'b0;
    expect_word(6'b110010, "R6 hold after latch falls");
    // R5 shifting with latch open, R6 transparent
    lat_en = 1'b1;
    shift_word(6'b000111, 6);
    expect_word(6'b000111, "R6 transparent follows shift");
    lat_en = 1'b0;
    tick(4);
    shift_word(6'b101000, 3);
    expect_word(6'b000111, "R6 held while shifting closed");
    lat_en = 1'b1;
    expect_word(6'b111101, "R5 shift regardless of latch");
    lat_en = 1'b0;
    // R8 preset decode
    do_reset(1'b0, 1'b0, 2'b00, 6'b111111);
    expect_word(6'b000000, "R8 pup 00");
    do_reset(1'b0, 1'b0, 2'b10, 6'b111111);
    expect_word(6'b010000, "R8 pup 10 8dB");
    do_reset(1'b0, 1'b0, 2'b01, 6'b111111);
    expect_word(6'b100000, "R8 pup 01 16dB");
    do_reset(1'b0, 1'b0, 2'b11, 6'b000001);
    expect_word(6'b111110, "R8 pup 11 31dB");
    par_word = 6'b010101;
    expect_word(6'b111110, "R4 parallel change ignored closed");
    // R9 presets ignored with latch high
    do_reset(1'b0, 1'b1, 2'b11, 6'b001010);
    expect_word(6'b001010, "R9 direct reset ignores pup");
    // R3 direct follow, R2 extremes
    par_word = 6'b111111;
    expect_word(6'b111111, "R2 all ones 31.5dB");
    par_word = 6'b000000;
    expect_word(6'b000000, "R2 all zeros min loss");
    par_word = 6'b011001;
    expect_word(6'b011001, "R3 direct follow");
    // R1 serial clocking ignored in parallel mode
    shift_word(6'b111111, 6);
    expect_word(6'b011001, "R1 parallel ignores serial");
    // R4 latched parallel
    lat_en = 1'b0;
    tick(4);
    par_word = 6'b100110;
    expect_word(6'b011001, "R4 closed holds");
    lat_en = 1'b1;
    tick(6);
    lat_en = 1'b0;
    tick(6);
    par_word = 6'b000011;
    expect_word(6'b100110, "R4 pulse captures");
    // R1 switch to serial: shift register holds 111111 from earlier
    ser_mode = 1'b1;
    lat_en = 1'b1;
    expect_word(6'b111111, "R1 serial path selected");
    wait (q.size() == 0);
    tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule